// File: doc/BRIEF.md
# Peripheral Clock Prescaler with Wait Gating

This block derives a family of peripheral timing strobes from one of three source clocks. Every source arrives as a single-cycle tick in the fabric clock domain, so the rate of the ticks is the source's rate. Every output is also a single-cycle tick. A two-bit select picks the peripheral source tick: main, PLL or on-chip oscillator. From the gated peripheral source, the block produces an undivided strobe, strobes divided by 8 and by 32, and a converter strobe that runs at the peripheral source rate.

A fifth, programmable strobe has its own two-bit source select. It can take the gated peripheral source, the XIN tick or the on-chip oscillator tick, and divides that source by twice a four-bit value n. When n is zero, the selected source passes through undivided. Gating inputs model wait mode, a stop-in-wait control and a main-clock stop. The gating rules decide which strobes freeze. Frozen dividers keep their count and resume from it.

Every output is registered: a source tick that the fabric clock samples at edge k appears on an output after edge k.

Top module: `pclk_prescaler`

## Requirements
- R1: While rst_n is low and on the first cycle after its release, all five outputs are 0, and every divide counter starts from zero.
- R2: The peripheral source is selected by pfc_sel: 00 main, 01 PLL, 10 or 11 on-chip oscillator. f1_tick and fad_tick pulse for one cycle after every gated peripheral source tick.
- R3: f8_tick pulses together with every 8th f1_tick pulse, counted from reset.
- R4: f32_tick pulses together with every 32nd f1_tick pulse, counted from reset.
- R5: For f2n_n from 1 to 15, f2n_tick pulses once per 2*f2n_n ticks of its selected source and never on two consecutive cycles.
- R6: With f2n_n = 0, f2n_tick pulses one cycle after every tick of its selected source.
- R7: The programmable source is selected by f2n_sel: 00 or 11 the gated peripheral source, 01 XIN, 10 on-chip oscillator.
- R8: When wait_mode and stop_in_wait are both 1, no peripheral source tick is counted or passed. f1, fad, f8 and f32 are then low on the next cycle. The XIN source of the programmable divider is blocked as well.
- R9: When main_stop is 1 and pfc_sel is 00, the peripheral source is blocked. With any other pfc_sel, main_stop has no effect.
- R10: With f2n_sel = 10, the programmable divider keeps counting on-chip oscillator ticks regardless of wait_mode, stop_in_wait and main_stop.
- R11: In any cycle where f2n_n or f2n_sel differs from its value in the previous cycle, the programmable counter returns to zero. A source tick in that cycle is discarded and gives no pulse.
- R12: While a divider's source is gated, its count is held, and counting resumes from that value when the gating ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock that samples all ticks |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_tick | input | 1 | Main clock tick |
| pll_tick | input | 1 | PLL clock tick |
| ring_tick | input | 1 | On-chip oscillator tick |
| xin_tick | input | 1 | XIN clock tick |
| pfc_sel | input | 2 | Peripheral source select |
| f2n_sel | input | 2 | Programmable divider source select |
| f2n_n | input | 4 | Programmable division value n (divide by 2n, 0 = bypass) |
| wait_mode | input | 1 | Device is in wait mode |
| stop_in_wait | input | 1 | Stop peripheral clocks in wait mode |
| main_stop | input | 1 | Main clock stop request |
| f1_tick | output | 1 | Peripheral source, undivided |
| f8_tick | output | 1 | Peripheral source divided by 8 |
| f32_tick | output | 1 | Peripheral source divided by 32 |
| fad_tick | output | 1 | Converter strobe at peripheral source rate |
| f2n_tick | output | 1 | Programmable divided strobe |

## Verification
Two pairs of events can fall in the same cycle. The first is a change of n or of the programmable select together with a source tick. The second is the start of wait gating together with the tick that would complete a division. The bench provokes both by redrawing the configuration and the gating controls at random each cycle while all four sources tick densely. A behavioural model holds plain integer counts and decides, cycle by cycle, whether a tick counts. The five outputs are compared against this model on every clock, so a dropped tick or a held count that is off by one shows up as a mismatched pulse.

// File: rtl/pclk_pkg.sv
package pclk_pkg;

    typedef enum logic [1:0] {
        PFC_MAIN     = 2'b00,
        PFC_PLL      = 2'b01,
        PFC_RING     = 2'b10,
        PFC_RING_ALT = 2'b11
    } pfc_src_e;

    typedef enum logic [1:0] {
        F2N_PFC     = 2'b00,
        F2N_XIN     = 2'b01,
        F2N_RING    = 2'b10,
        F2N_PFC_ALT = 2'b11
    } f2n_src_e;

    typedef struct packed {
        logic wait_mode;
        logic stop_in_wait;
        logic main_stop;
    } gate_ctl_t;

endpackage

// File: rtl/pclk_src_gate.sv
module pclk_src_gate
    import pclk_pkg::*;
(
    input  logic      main_tick,
    input  logic      pll_tick,
    input  logic      ring_tick,
    input  logic      xin_tick,
    input  pfc_src_e  pfc_sel,
    input  f2n_src_e  f2n_sel,
    input  gate_ctl_t ctl,
    output logic      pfc_tick,
    output logic      f2n_src_tick
);

    logic wait_hold;
    logic pfc_run;
    logic pfc_raw;

    always_comb begin
        wait_hold = ctl.wait_mode & ctl.stop_in_wait;
        pfc_run   = ~wait_hold & ~(ctl.main_stop & (pfc_sel == PFC_MAIN));

        unique case (pfc_sel)
            PFC_MAIN:     pfc_raw = main_tick;
            PFC_PLL:      pfc_raw = pll_tick;
            PFC_RING:     pfc_raw = ring_tick;
            PFC_RING_ALT: pfc_raw = ring_tick;
            default:      pfc_raw = 1'b0;
        endcase

        pfc_tick = pfc_raw & pfc_run;

        unique case (f2n_sel)
            F2N_PFC:     f2n_src_tick = pfc_tick;
            F2N_XIN:     f2n_src_tick = xin_tick & ~wait_hold;
            F2N_RING:    f2n_src_tick = ring_tick;
            F2N_PFC_ALT: f2n_src_tick = pfc_tick;
            default:     f2n_src_tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/pclk_fixed_div.sv
module pclk_fixed_div #(
    parameter int unsigned DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_tick,
    output logic out_tick
);

    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          out;
    } fd_state_t;

    fd_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.out = 1'b0;
        if (in_tick) begin
            if (st_q.cnt == LAST) begin
                st_d.cnt = '0;
                st_d.out = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_tick = st_q.out;

endmodule

// File: rtl/pclk_prog_div.sv
module pclk_prog_div #(
    parameter int unsigned N_W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_tick,
    input  logic [N_W-1:0] n_div,
    input  logic [1:0]     src_sel,
    output logic           out_tick
);

    localparam int unsigned CW = N_W + 1;

    typedef struct packed {
        logic [CW-1:0]  cnt;
        logic [N_W-1:0] n;
        logic [1:0]     sel;
        logic           out;
    } pd_state_t;

    pd_state_t st_d, st_q;
    logic      cfg_moved;
    logic [CW-1:0] last;

    always_comb begin
        cfg_moved = (n_div != st_q.n) || (src_sel != st_q.sel);
        last      = {n_div, 1'b0} - CW'(1);
        st_d      = st_q;
        st_d.n    = n_div;
        st_d.sel  = src_sel;
        st_d.out  = 1'b0;
        if (cfg_moved) begin
            st_d.cnt = '0;
        end else if (in_tick) begin
            if (n_div == '0) begin
                st_d.cnt = '0;
                st_d.out = 1'b1;
            end else if (st_q.cnt == last) begin
                st_d.cnt = '0;
                st_d.out = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_tick = st_q.out;

    // R5: a divided pulse is never followed directly by another
    a_r5_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        (out_tick && n_div != '0) |=> !out_tick);

endmodule

// File: rtl/pclk_prescaler.sv
module pclk_prescaler
    import pclk_pkg::*;
#(
    parameter int unsigned MID_DIV  = 8,
    parameter int unsigned SLOW_DIV = 32,
    parameter int unsigned N_W      = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           main_tick,
    input  logic           pll_tick,
    input  logic           ring_tick,
    input  logic           xin_tick,
    input  logic [1:0]     pfc_sel,
    input  logic [1:0]     f2n_sel,
    input  logic [N_W-1:0] f2n_n,
    input  logic           wait_mode,
    input  logic           stop_in_wait,
    input  logic           main_stop,
    output logic           f1_tick,
    output logic           f8_tick,
    output logic           f32_tick,
    output logic           fad_tick,
    output logic           f2n_tick
);

    localparam int unsigned NUM_FIX = 3;
    localparam int unsigned FIX_DIV [NUM_FIX] = '{1, MID_DIV, SLOW_DIV};

    gate_ctl_t          ctl;
    logic               pfc_tick;
    logic               f2n_src_tick;
    logic [NUM_FIX-1:0] fix_out;

    assign ctl = '{wait_mode: wait_mode, stop_in_wait: stop_in_wait, main_stop: main_stop};

    pclk_src_gate u_gate (
        .main_tick    (main_tick),
        .pll_tick     (pll_tick),
        .ring_tick    (ring_tick),
        .xin_tick     (xin_tick),
        .pfc_sel      (pfc_src_e'(pfc_sel)),
        .f2n_sel      (f2n_src_e'(f2n_sel)),
        .ctl          (ctl),
        .pfc_tick     (pfc_tick),
        .f2n_src_tick (f2n_src_tick)
    );

    for (genvar gi = 0; gi < NUM_FIX; gi++) begin : g_fix
        pclk_fixed_div #(.DIV(FIX_DIV[gi])) u_div (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_tick  (pfc_tick),
            .out_tick (fix_out[gi])
        );
    end

    pclk_fixed_div #(.DIV(1)) u_conv (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_tick  (pfc_tick),
        .out_tick (fad_tick)
    );

    pclk_prog_div #(.N_W(N_W)) u_prog (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_tick  (f2n_src_tick),
        .n_div    (f2n_n),
        .src_sel  (f2n_sel),
        .out_tick (f2n_tick)
    );

    assign f1_tick  = fix_out[0];
    assign f8_tick  = fix_out[1];
    assign f32_tick = fix_out[2];

    // R8: wait with stop-in-wait silences the peripheral strobes next cycle
    a_r8_wait_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_mode && stop_in_wait) |=> (!f1_tick && !fad_tick && !f8_tick));

    // R9: main clock stop blocks the converter strobe when main is the source
    a_r9_main_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (main_stop && pfc_sel == 2'b00) |=> !fad_tick);

    // R3: the divide-by-8 strobe only lands on an undivided strobe
    a_r3_mid_on_f1: assert property (@(posedge clk) disable iff (!rst_n)
        f8_tick |-> f1_tick);

    // R4: the divide-by-32 strobe only lands on a divide-by-8 strobe
    a_r4_slow_on_mid: assert property (@(posedge clk) disable iff (!rst_n)
        f32_tick |-> f8_tick);

endmodule

// File: tb/pclk_prescaler_tb.sv
module pclk_prescaler_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       main_tick = 1'b0, pll_tick = 1'b0, ring_tick = 1'b0, xin_tick = 1'b0;
    logic [1:0] pfc_sel = 2'b00, f2n_sel = 2'b00;
    logic [3:0] f2n_n = 4'd0;
    logic       wait_mode = 1'b0, stop_in_wait = 1'b0, main_stop = 1'b0;
    logic       f1_tick, f8_tick, f32_tick, fad_tick, f2n_tick;

    int    n_chk = 0;
    int    n_fail = 0;
    string cur_tag = "R1";
    bit    done = 1'b0;

    always #4 clk = ~clk;

    pclk_prescaler u_dut (
        .clk(clk), .rst_n(rst_n),
        .main_tick(main_tick), .pll_tick(pll_tick), .ring_tick(ring_tick), .xin_tick(xin_tick),
        .pfc_sel(pfc_sel), .f2n_sel(f2n_sel), .f2n_n(f2n_n),
        .wait_mode(wait_mode), .stop_in_wait(stop_in_wait), .main_stop(main_stop),
        .f1_tick(f1_tick), .f8_tick(f8_tick), .f32_tick(f32_tick),
        .fad_tick(fad_tick), .f2n_tick(f2n_tick)
    );

    // Behavioural reference: integer counts, decided on every clock edge
    int m8 = 0, m32 = 0, m2n = 0, prev_n = 0, prev_sel = 0;
    bit e1 = 0, e8 = 0, e32 = 0, ead = 0, e2n = 0;

    always @(posedge clk) begin
        bit hold, pfc_ok, src, g, s2;
        if (!rst_n) begin
            m8 = 0; m32 = 0; m2n = 0; prev_n = 0; prev_sel = 0;
            e1 = 0; e8 = 0; e32 = 0; ead = 0; e2n = 0;
        end else begin
            hold   = wait_mode && stop_in_wait;
            pfc_ok = !hold && !(main_stop && pfc_sel == 2'b00);
            case (pfc_sel)
                2'b00:   src = main_tick;
                2'b01:   src = pll_tick;
                default: src = ring_tick;
            endcase
            g   = src && pfc_ok;
            e1  = g;
            ead = g;
            e8  = 0;
            e32 = 0;
            if (g) begin
                m8++;  if (m8 == 8)   begin e8 = 1;  m8 = 0;  end
                m32++; if (m32 == 32) begin e32 = 1; m32 = 0; end
            end
            case (f2n_sel)
                2'b01:   s2 = xin_tick && !hold;
                2'b10:   s2 = ring_tick;
                default: s2 = g;
            endcase
            e2n = 0;
            if (int'(f2n_n) != prev_n || int'(f2n_sel) != prev_sel) begin
                m2n = 0;
            end else if (s2) begin
                if (f2n_n == 0) e2n = 1;
                else begin
                    m2n++;
                    if (m2n == 2 * int'(f2n_n)) begin e2n = 1; m2n = 0; end
                end
            end
            prev_n   = int'(f2n_n);
            prev_sel = int'(f2n_sel);
        end
    end

    task automatic chk(input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", cur_tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            chk("f1", f1_tick, e1);
            chk("fad", fad_tick, ead);
            chk("f8", f8_tick, e8);
            chk("f32", f32_tick, e32);
            chk("f2n", f2n_tick, e2n);
        end
    end

    task automatic run(input int cycles, input int pct, input int cfg_pct, input int gate_pct);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            main_tick = ($urandom_range(99) < pct);
            pll_tick  = ($urandom_range(99) < pct);
            ring_tick = ($urandom_range(99) < pct);
            xin_tick  = ($urandom_range(99) < pct);
            if ($urandom_range(99) < cfg_pct) begin
                f2n_n   = 4'($urandom_range(15));
                f2n_sel = 2'($urandom_range(3));
            end
            if ($urandom_range(99) < gate_pct) begin
                wait_mode    = $urandom_range(1);
                stop_in_wait = $urandom_range(1);
                main_stop    = $urandom_range(1);
            end
        end
    endtask

    task automatic report;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        report();
    end

    initial begin
        // R1: outputs quiet through reset and release
        cur_tag = "R1";
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R2, R3, R4: each peripheral source, counts carried across
        cur_tag = "R2/R3/R4";
        f2n_n = 4'd3;
        for (int s = 0; s < 4; s++) begin
            pfc_sel = 2'(s);
            run(300, 60, 0, 0);
        end

        // R5, R7: every division value on every programmable source
        cur_tag = "R5/R7";
        for (int s = 0; s < 4; s++) begin
            for (int n = 1; n < 16; n++) begin
                @(negedge clk);
                f2n_sel = 2'(s);
                f2n_n   = 4'(n);
                run(80, 70, 0, 0);
            end
        end

        // R6: bypass with n = 0
        cur_tag = "R6";
        f2n_n = 4'd0;
        for (int s = 0; s < 4; s++) begin
            f2n_sel = 2'(s);
            run(100, 50, 0, 0);
        end

        // R8: wait with stop-in-wait gates peripheral and XIN sources
        cur_tag = "R8";
        f2n_n = 4'd2;
        for (int s = 0; s < 2; s++) begin
            f2n_sel = 2'(s);
            wait_mode = 1'b1; stop_in_wait = 1'b1;
            run(150, 80, 0, 0);
            stop_in_wait = 1'b0;
            run(150, 80, 0, 0);
            wait_mode = 1'b0;
        end

        // R9: main stop only matters when main is the source
        cur_tag = "R9";
        main_stop = 1'b1;
        for (int s = 0; s < 3; s++) begin
            pfc_sel = 2'(s);
            run(200, 70, 0, 0);
        end
        main_stop = 1'b0;

        // R10: on-chip source keeps the programmable output running in wait
        cur_tag = "R10";
        f2n_sel = 2'b10; f2n_n = 4'd1;
        wait_mode = 1'b1; stop_in_wait = 1'b1; main_stop = 1'b1;
        run(200, 80, 0, 0);
        wait_mode = 1'b0; stop_in_wait = 1'b0; main_stop = 1'b0;

        // R11: configuration changes, often on a source tick
        cur_tag = "R11";
        run(1500, 90, 20, 0);

        // R12: gating toggles mid-count, counts must resume
        cur_tag = "R12";
        f2n_sel = 2'b00; f2n_n = 4'd5; pfc_sel = 2'b00;
        run(2000, 80, 0, 30);

        // R8/R11: everything at once
        cur_tag = "R8/R11/R12";
        run(3000, 85, 10, 25);

        @(negedge clk);
        report();
    end

endmodule